// File: doc/BRIEF.md
# Split-Mode Precision Gamma Palette

This block is the colour correction palette of a display pipe. A single RAM of 1024 packed RGB entries holds two tables: entries 0 to 511 form the degamma table and entries 512 to 1023 form the gamma table. Software loads the RAM through two registers. An index register sets the starting entry, the auto-increment enable and the split addressing mode. A data register then stores or returns one packed entry at the current pointer.

Each pixel channel passes through both tables. The top nine bits of the channel select a degamma entry. The top nine bits of that entry's channel field then select a gamma entry, whose 10-bit result is left-justified into a 16-bit output. The input channel has one extra bit above full scale. When that bit is set, the channel skips the table result and outputs a per-channel 16-bit maximum register instead. This gives a defined output for values above 1.0.

Top module: `prec_palette`

## Requirements
- R1: Register address 0 is the index register. A write sets split mode from bit 31, auto-increment from bit 15 and the entry pointer from bits 9:0. A read returns split in bit 31, auto-increment in bit 15 and the current pointer in bits 9:0, with all other bits zero.
- R2: Register address 1 is the data register. A write stores red from bits 29:20, green from bits 19:10 and blue from bits 9:0 into the entry at the pointer. A read returns that entry in the same bit positions. A read never moves the pointer.
- R3: With auto-increment set, each data write advances the pointer by one. With auto-increment clear, a data write leaves the pointer unchanged.
- R4: With split mode clear, an auto-incrementing data write at entry 1023 wraps the pointer to 0.
- R5: With split mode set, the pointer stays inside its own half of the RAM. An increment from 511 returns it to 0, and an increment from 1023 returns it to 512.
- R6: Register addresses 2, 3 and 4 hold the 16-bit red, green and blue maximum values. Each resets to 0xFFFF, takes bits 15:0 of a write and reads back zero-extended.
- R7: A pixel channel whose bit 10 is clear produces {G, 6'b0} on its output, valid two cycles after `pix_valid`. Here D is the degamma entry at the channel's bits 9:1, and G is the gamma entry at 512 plus bits 9:1 of D's field for that channel.
- R8: A pixel channel whose bit 10 is set produces that channel's maximum register value, with the same two-cycle latency.
- R9: Writing 0 to the index register leaves split mode off, auto-increment off and the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata after the next edge |
| reg_addr | input | 3 | Register select: 0 index, 1 data, 2/3/4 red/green/blue maximum |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pix_valid | input | 1 | Pixel input valid |
| pix_in | input | 33 | Pixel channels, 11 bits each: red 32:22, green 21:11, blue 10:0 |
| out_valid | output | 1 | Pixel output valid |
| pix_out | output | 48 | Output channels, 16 bits each: red 47:32, green 31:16, blue 15:0 |

## Verification
Both tables are loaded with distinct arithmetic functions for each channel, such as a linear ramp, a descending line and a modular stride. Every degamma entry is then reached by a sweep over all 1024 in-range codes. Because the channels use different functions, a swapped field, a swapped table half or a wrong index slice gives a visibly different output. Over-range inputs are mixed with in-range inputs on other channels, first against the reset maxima and then against written maxima, to show that the clamp is applied per channel. Pointer tests load a table across its boundary in split mode and wrap entry 1023 in single mode. They also check that reads and non-incrementing writes leave the pointer where it was.

// File: rtl/prec_palette.sv
module prec_palette #(
  parameter int AW = 10,
  parameter int CW = 10,
  parameter int MW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pix_valid,
  input  logic [3*(CW+1)-1:0] pix_in,
  output logic              out_valid,
  output logic [3*MW-1:0]   pix_out
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = 3 * CW;
  localparam int HW    = AW - 1;
  localparam int CIW   = CW + 1;

  logic [EW-1:0] ram [DEPTH];
  logic          split_q, ainc_q;
  logic [AW-1:0] ptr_q, ptr_inc;
  logic [MW-1:0] max_q [3];
  logic          v1_q, v2_q;

  wire wr_idx = reg_wr && reg_addr == 3'd0;
  wire wr_dat = reg_wr && reg_addr == 3'd1;

  assign ptr_inc = split_q ? {ptr_q[AW-1], ptr_q[HW-1:0] + HW'(1)} : ptr_q + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_q <= 1'b0;
      ainc_q  <= 1'b0;
      ptr_q   <= '0;
      for (int k = 0; k < 3; k++) max_q[k] <= '1;
    end else begin
      if (wr_idx) begin
        split_q <= reg_wdata[31];
        ainc_q  <= reg_wdata[15];
        ptr_q   <= reg_wdata[AW-1:0];
      end else if (wr_dat && ainc_q) begin
        ptr_q <= ptr_inc;
      end
      for (int k = 0; k < 3; k++)
        if (reg_wr && reg_addr == 3'(2 + k)) max_q[k] <= reg_wdata[MW-1:0];
    end
  end

  always_ff @(posedge clk)
    if (wr_dat) ram[ptr_q] <= reg_wdata[EW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (reg_addr)
        3'd0: begin
          reg_rdata[31]     <= split_q;
          reg_rdata[15]     <= ainc_q;
          reg_rdata[AW-1:0] <= ptr_q;
        end
        3'd1: reg_rdata[EW-1:0] <= ram[ptr_q];
        3'd2: reg_rdata[MW-1:0] <= max_q[0];
        3'd3: reg_rdata[MW-1:0] <= max_q[1];
        3'd4: reg_rdata[MW-1:0] <= max_q[2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= pix_valid;
      v2_q <= v1_q;
    end
  end
  assign out_valid = v2_q;

  for (genvar k = 0; k < 3; k++) begin : g_chan
    wire [CIW-1:0] chin = pix_in[k*CIW +: CIW];
    logic [CW-1:0] deg_q, gam_q;
    logic          ov1_q, ov2_q;
    wire [EW-1:0]  dword = ram[{1'b0, chin[CW-1 -: HW]}];
    wire [EW-1:0]  gword = ram[{1'b1, deg_q[CW-1 -: HW]}];
    always_ff @(posedge clk) begin
      deg_q <= dword[k*CW +: CW];
      ov1_q <= chin[CW];
      gam_q <= gword[k*CW +: CW];
      ov2_q <= ov1_q;
    end
    assign pix_out[k*MW +: MW] = ov2_q ? max_q[2-k] : {gam_q, {(MW-CW){1'b0}}};
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##2 out_valid);
  assert_max_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2) |=> max_q[0] == $past(reg_wdata[MW-1:0]));
  assert_wrap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ainc_q && !split_q && (&ptr_q)) |=> ptr_q == '0);
  assert_wrap_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ainc_q && split_q && (&ptr_q[HW-1:0])) |=> (ptr_q[HW-1:0] == '0 && ptr_q[AW-1] == $past(ptr_q[AW-1])));
  assert_read_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> $stable(ptr_q));
  assert_no_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !ainc_q) |=> $stable(ptr_q));
  assert_clean_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx && reg_wdata == 32'd0) |=> (!split_q && !ainc_q && ptr_q == '0));
endmodule

// File: tb/prec_palette_bench.sv
module prec_palette_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_valid = 1'b0;
  logic [32:0] pix_in = '0;
  logic        out_valid;
  logic [47:0] pix_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [15:0] mx [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  prec_palette u_prec_palette (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_valid(pix_valid), .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out)
  );

  function automatic int dg(int ch, int i);
    if (ch == 2) return i * 1023 / 511;
    if (ch == 1) return 1023 - 2 * i;
    return (i * 37) % 1024;
  endfunction

  function automatic int gm(int ch, int j);
    if (ch == 2) return (j * 3) % 1024;
    if (ch == 1) return j * 2;
    return 1023 - j;
  endfunction

  function automatic logic [31:0] dword(int i);
    return {2'b00, 10'(dg(2, i)), 10'(dg(1, i)), 10'(dg(0, i))};
  endfunction

  function automatic logic [31:0] gword(int j);
    return {2'b00, 10'(gm(2, j)), 10'(gm(1, j)), 10'(gm(0, j))};
  endfunction

  function automatic logic [15:0] expch(int ch, logic [10:0] v);
    int d;
    if (v[10]) return mx[2-ch];
    d = dg(ch, int'(v[9:1]));
    return {10'(gm(ch, d / 2)), 6'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pixel(input logic [10:0] r, input logic [10:0] g, input logic [10:0] b, input string req);
    logic [47:0] e;
    @(negedge clk);
    pix_valid = 1'b1; pix_in = {r, g, b};
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    e = {expch(2, r), expch(1, g), expch(0, b)};
    chk(out_valid === 1'b1 && pix_out === e, req, {15'b0, out_valid, pix_out}, {16'h0001, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int k = 0; k < 3; k++) mx[k] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rreg(3'd0, rd); chk(rd === 32'h0, "R9 reset index", rd, 0);
    chk(out_valid === 1'b0, "R7 reset out_valid", out_valid, 0);
    rreg(3'd2, rd); chk(rd === 32'hFFFF, "R6 reset red max", rd, 32'hFFFF);
    rreg(3'd3, rd); chk(rd === 32'hFFFF, "R6 reset green max", rd, 32'hFFFF);
    rreg(3'd4, rd); chk(rd === 32'hFFFF, "R6 reset blue max", rd, 32'hFFFF);

    wreg(3'd0, 32'h8000_8005);
    rreg(3'd0, rd); chk(rd === 32'h8000_8005, "R1 index fields", rd, 32'h8000_8005);

    wreg(3'd0, 32'h8000_8000);
    for (int i = 0; i < 512; i++) wreg(3'd1, dword(i));
    rreg(3'd0, rd); chk(rd === 32'h8000_8000, "R5 degamma half wraps to 0", rd, 32'h8000_8000);
    wreg(3'd0, 32'h8000_8200);
    for (int j = 0; j < 512; j++) wreg(3'd1, gword(j));
    rreg(3'd0, rd); chk(rd === 32'h8000_8200, "R5 gamma half wraps to 512", rd, 32'h8000_8200);

    wreg(3'd0, 32'h8000_0007);
    rreg(3'd1, rd); chk(rd === dword(7), "R2 data read packing", rd, dword(7));
    rreg(3'd1, rd); chk(rd === dword(7), "R2 repeated read same entry", rd, dword(7));
    rreg(3'd0, rd); chk(rd === 32'h8000_0007, "R2 read keeps pointer", rd, 32'h8000_0007);
    wreg(3'd1, dword(7));
    rreg(3'd0, rd); chk(rd === 32'h8000_0007, "R3 no auto-increment", rd, 32'h8000_0007);

    wreg(3'd0, 32'h0000_8000 | 32'd600);
    wreg(3'd1, gword(88));
    wreg(3'd1, gword(89));
    rreg(3'd0, rd); chk(rd === (32'h0000_8000 | 32'd602), "R3 auto-increment by one", rd, 32'h0000_8000 | 32'd602);
    wreg(3'd0, 32'h0000_8000 | 32'd601);
    rreg(3'd1, rd); chk(rd === gword(89), "R2 gamma entry readback", rd, gword(89));

    wreg(3'd0, 32'h0000_83FF);
    wreg(3'd1, gword(511));
    rreg(3'd0, rd); chk(rd === 32'h0000_8000, "R4 single mode wrap", rd, 32'h0000_8000);
    rreg(3'd1, rd); chk(rd === dword(0), "R4 entry 0 after wrap", rd, dword(0));

    wreg(3'd0, 32'h0);
    rreg(3'd0, rd); chk(rd === 32'h0, "R9 clean index", rd, 0);

    for (int v = 0; v < 1024; v++)
      pixel(11'(v), 11'(1023 - v), 11'((v * 5) % 1024), "R7 in-range sweep");

    pixel(11'h400, 11'h7FF, 11'h5AA, "R8 default maxima");
    wreg(3'd2, 32'hFFFF_1234); mx[0] = 16'h1234;
    wreg(3'd3, 32'h0000_ABCD); mx[1] = 16'hABCD;
    wreg(3'd4, 32'h0000_0F0F); mx[2] = 16'h0F0F;
    rreg(3'd2, rd); chk(rd === 32'h1234, "R6 red max low half", rd, 32'h1234);
    rreg(3'd3, rd); chk(rd === 32'hABCD, "R6 green max", rd, 32'hABCD);
    rreg(3'd4, rd); chk(rd === 32'h0F0F, "R6 blue max", rd, 32'h0F0F);
    pixel(11'h400, 11'h123, 11'h7FF, "R8 red and blue clamp");
    pixel(11'h0FF, 11'h500, 11'h010, "R8 green clamp");
    pixel(11'h401, 11'h402, 11'h403, "R8 all clamp");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule